// File: doc/BRIEF.md
# Page Overlay Remap Controller

This controller lets a bank of on-chip SRAM pages take the place of chosen 4 KiB regions of main memory. Software programs one control word per SRAM page with the physical page frame number to be covered. Once the page is active, any read request whose frame number matches is steered to that SRAM page. Requests that match nothing pass through to main memory unchanged. The SRAM is not filled from main memory. Software must copy the data in itself after the page becomes active.

Configuration uses a simple register port. One select bit chooses between the per-page control words and two global registers: a control register and a block-mode register. Each page word can be programmed once. Protection comes at three levels: the page's own lock, a lock in the block-mode register, and a global lock. Each level, once set, freezes the state below it until reset. Activation takes two steps: the enable bit is stored first, and the busy flag follows one cycle later to confirm the overlay is live. The block-mode enable suppresses all per-page hits and must be cleared before page overlay works.

Top module: `pov_remap_ctrl`

## Requirements
- R1: After reset every page word reads 0x00000000, the block register reads 0x00000000, the control register reads 0x007F0010 (size field bits 22:16 = page count minus one = 127, available bit 4 = 1), and no lookup hits.
- R2: A page word reads back with flush-on-sleep at bit 31, enable at bit 28, lock at bit 27, init-in-progress at bit 26, busy at bit 24 and the 20-bit frame number in bits 19:0; all other bits read 0.
- R3: A page write with bit 28 set stores the enable at the write edge; a read issued in the next cycle shows enable=1, init=1, busy=0, and from the following cycle busy=1 and init=0.
- R4: A lookup of an address whose bits 31:12 equal the frame number of a busy page gives, one cycle later, rsp_hit=1, rsp_page = that page, and rsp_addr = {page, address bits 11:0} zero-extended.
- R5: A lookup that matches no busy page gives rsp_hit=0 and rsp_addr equal to the request address; a stored but not enabled entry never matches.
- R6: When several busy pages hold the same frame number, the lowest page index is reported.
- R7: A write to a page that is enabled, busy or locked (bit 27) is ignored, and its word reads back unchanged.
- R8: Writing bit 2 of the control register sets a global lock that stays set until reset; while it is set, writes to the control register, the block register and every page word are ignored.
- R9: Setting bit 27 of the block register locks it until reset; while locked, writes to the block register and to every page word are ignored, while the control register stays writable.
- R10: Writing the block register with bit 28 set and bit 29 clear enables block mode, which reads back in both bit 28 and busy bit 24 and blocks every page hit; a write with bit 29 set clears block mode even if bit 28 is also set.
- R11: Control register bits 0 and 3 are read/write; bit 4 and bits 22:16 are read-only and ignore written values.
- R12: Every lookup takes exactly one cycle: rsp_valid is high in the cycle after req_valid and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe; cfg_rdata updates one cycle later |
| cfg_global | input | 1 | 0 selects page word cfg_idx, 1 selects a global register (0 control, 1 block) |
| cfg_idx | input | 7 | Page index or global register number |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the last read strobe |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 32 | Physical address of the request |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Request falls in an active overlay page |
| rsp_page | output | 7 | SRAM page index on a hit, 0 otherwise |
| rsp_addr | output | 32 | SRAM byte address on a hit, request address on a miss |

## Verification
The assertions assume that reset is asserted before the first checked edge, so that every sticky flag starts cleared. They also assume that cfg_idx always names an existing page. The default page count is a power of two, so no index is out of range. The bench drives every input at the falling edge and holds it for one full cycle. It uses only page indices and global register numbers 0 and 1, and it applies reset at the start and again in the middle of the run, after the global lock has been tested.

// File: rtl/pov_pkg.sv
`timescale 1ns/1ps
package pov_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int REG_W      = 32;
    localparam int SIZE_W     = 7;

    // page control word bit positions
    localparam int PG_FLUSH_B = 31;
    localparam int PG_EN_B    = 28;
    localparam int PG_LOCK_B  = 27;
    localparam int PG_INIT_B  = 26;
    localparam int PG_BUSY_B  = 24;

    // global control register bit positions
    localparam int GC_ECC_B   = 0;
    localparam int GC_LOCK_B  = 2;
    localparam int GC_ALL_B   = 3;
    localparam int GC_AVAIL_B = 4;
    localparam int GC_SIZE_LO = 16;

    // block-mode register bit positions
    localparam int BK_FLUSH_B = 31;
    localparam int BK_DIS_B   = 29;
    localparam int BK_EN_B    = 28;
    localparam int BK_LOCK_B  = 27;
    localparam int BK_BUSY_B  = 24;

    // global register numbers
    localparam int GREG_CTRL  = 0;
    localparam int GREG_BLOCK = 1;

    typedef struct packed {
        logic ecc_en;
        logic en_all;
        logic glock;
        logic blk_flush;
        logic blk_en;
        logic blk_lock;
    } glob_t;
endpackage

// File: rtl/pov_global_regs.sv
`timescale 1ns/1ps
module pov_global_regs
    import pov_pkg::*;
#(
    parameter int NUM_PAGES = 128,
    parameter int IDX_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wdata,
    output logic             glock,
    output logic             blk_lock,
    output logic             blk_en,
    output logic [REG_W-1:0] ctrl_word,
    output logic [REG_W-1:0] blk_word
);
    glob_t st_d, st_q;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        if (wr_en && !st_q.glock) begin
            if (wr_idx == IDX_W'(GREG_CTRL)) begin
                st_d.ecc_en = wdata[GC_ECC_B];
                st_d.en_all = wdata[GC_ALL_B];
                st_d.glock  = wdata[GC_LOCK_B];
            end else if (wr_idx == IDX_W'(GREG_BLOCK) && !st_q.blk_lock) begin
                st_d.blk_flush = wdata[BK_FLUSH_B];
                st_d.blk_lock  = wdata[BK_LOCK_B];
                st_d.blk_en    = wdata[BK_EN_B] && !wdata[BK_DIS_B];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[GC_ECC_B]   = st_q.ecc_en;
        ctrl_word[GC_LOCK_B]  = st_q.glock;
        ctrl_word[GC_ALL_B]   = st_q.en_all;
        ctrl_word[GC_AVAIL_B] = 1'b1;
        ctrl_word[GC_SIZE_LO +: SIZE_W] = SIZE_W'(NUM_PAGES - 1);
        blk_word = '0;
        blk_word[BK_FLUSH_B] = st_q.blk_flush;
        blk_word[BK_EN_B]    = st_q.blk_en;
        blk_word[BK_LOCK_B]  = st_q.blk_lock;
        blk_word[BK_BUSY_B]  = st_q.blk_en;
    end

    assign glock    = st_q.glock;
    assign blk_lock = st_q.blk_lock;
    assign blk_en   = st_q.blk_en;
endmodule

// File: rtl/pov_page_table.sv
`timescale 1ns/1ps
module pov_page_table #(
    parameter int NUM_PAGES = 128,
    parameter int PFN_W     = 20,
    parameter int IDX_W     = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic                              wr_enable,
    input  logic                              wr_lock,
    input  logic                              wr_flush,
    input  logic [PFN_W-1:0]                  wr_pfn,
    output logic [NUM_PAGES-1:0]              pg_en,
    output logic [NUM_PAGES-1:0]              pg_lock,
    output logic [NUM_PAGES-1:0]              pg_busy,
    output logic [NUM_PAGES-1:0]              pg_flush,
    output logic [NUM_PAGES-1:0][PFN_W-1:0]   pg_pfn
);
    typedef struct packed {
        logic [NUM_PAGES-1:0]            en;
        logic [NUM_PAGES-1:0]            lock;
        logic [NUM_PAGES-1:0]            busy;
        logic [NUM_PAGES-1:0]            flush;
        logic [NUM_PAGES-1:0][PFN_W-1:0] pfn;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        // activation completes one cycle after the enable is stored
        t_d.busy = t_q.busy | t_q.en;
        if (wr_en && !t_q.en[wr_idx] && !t_q.busy[wr_idx] && !t_q.lock[wr_idx]) begin
            t_d.en[wr_idx]    = wr_enable;
            t_d.lock[wr_idx]  = wr_lock;
            t_d.flush[wr_idx] = wr_flush;
            t_d.pfn[wr_idx]   = wr_pfn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pg_en    = t_q.en;
    assign pg_lock  = t_q.lock;
    assign pg_busy  = t_q.busy;
    assign pg_flush = t_q.flush;
    assign pg_pfn   = t_q.pfn;
endmodule

// File: rtl/pov_lookup.sv
`timescale 1ns/1ps
module pov_lookup
    import pov_pkg::*;
#(
    parameter int NUM_PAGES = 128,
    parameter int ADDR_W    = 32,
    parameter int PFN_W     = 20,
    parameter int IDX_W     = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [NUM_PAGES-1:0]            active,
    input  logic [NUM_PAGES-1:0][PFN_W-1:0] pfn,
    output logic                            rsp_valid,
    output logic                            rsp_hit,
    output logic [IDX_W-1:0]                rsp_page,
    output logic [ADDR_W-1:0]               rsp_addr
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  page;
        logic [ADDR_W-1:0] addr;
    } rsp_t;

    rsp_t                 r_d, r_q;
    logic [NUM_PAGES-1:0] match;
    logic [IDX_W-1:0]     sel;
    logic                 any;

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_cmp
        assign match[g] = active[g] && (pfn[g] == req_addr[ADDR_W-1:PAGE_SHIFT]);
    end

    always_comb begin
        sel = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (match[i]) sel = IDX_W'(i);
        end
        any        = |match;
        r_d.valid  = req_valid;
        r_d.hit    = req_valid && any;
        r_d.page   = (req_valid && any) ? sel : '0;
        r_d.addr   = (req_valid && any) ? ADDR_W'({sel, req_addr[PAGE_SHIFT-1:0]}) : req_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.valid;
    assign rsp_hit   = r_q.hit;
    assign rsp_page  = r_q.page;
    assign rsp_addr  = r_q.addr;
endmodule

// File: rtl/pov_remap_ctrl.sv
`timescale 1ns/1ps
module pov_remap_ctrl
    import pov_pkg::*;
#(
    parameter int NUM_PAGES = 128,
    parameter int ADDR_W    = 32,
    localparam int IDX_W    = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic              cfg_global,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_page,
    output logic [ADDR_W-1:0] rsp_addr
);
    localparam int PFN_W = ADDR_W - PAGE_SHIFT;

    logic                            glock, blk_lock, blk_en;
    logic [REG_W-1:0]                ctrl_word, blk_word;
    logic [NUM_PAGES-1:0]            pg_en, pg_lock, pg_busy, pg_flush, active;
    logic [NUM_PAGES-1:0][PFN_W-1:0] pg_pfn;
    logic                            pg_wr;
    logic [REG_W-1:0]                rdata_d, rdata_q;

    pov_global_regs #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_glob (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr && cfg_global),
        .wr_idx(cfg_idx), .wdata(cfg_wdata), .glock(glock),
        .blk_lock(blk_lock), .blk_en(blk_en),
        .ctrl_word(ctrl_word), .blk_word(blk_word)
    );

    assign pg_wr = cfg_wr && !cfg_global && !glock && !blk_lock;

    pov_page_table #(.NUM_PAGES(NUM_PAGES), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(pg_wr), .wr_idx(cfg_idx),
        .wr_enable(cfg_wdata[PG_EN_B]), .wr_lock(cfg_wdata[PG_LOCK_B]),
        .wr_flush(cfg_wdata[PG_FLUSH_B]), .wr_pfn(cfg_wdata[PFN_W-1:0]),
        .pg_en(pg_en), .pg_lock(pg_lock), .pg_busy(pg_busy),
        .pg_flush(pg_flush), .pg_pfn(pg_pfn)
    );

    // block mode takes the SRAM away from page overlay
    assign active = pg_busy & {NUM_PAGES{!blk_en}};

    pov_lookup #(.NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_lk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .active(active), .pfn(pg_pfn), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_page(rsp_page), .rsp_addr(rsp_addr)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (cfg_rd) begin
            rdata_d = '0;
            if (cfg_global) begin
                if (cfg_idx == IDX_W'(GREG_CTRL))       rdata_d = ctrl_word;
                else if (cfg_idx == IDX_W'(GREG_BLOCK)) rdata_d = blk_word;
            end else begin
                rdata_d[PG_FLUSH_B]  = pg_flush[cfg_idx];
                rdata_d[PG_EN_B]     = pg_en[cfg_idx];
                rdata_d[PG_LOCK_B]   = pg_lock[cfg_idx];
                rdata_d[PG_INIT_B]   = pg_en[cfg_idx] && !pg_busy[cfg_idx];
                rdata_d[PG_BUSY_B]   = pg_busy[cfg_idx];
                rdata_d[PFN_W-1:0]   = pg_pfn[cfg_idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign cfg_rdata = rdata_q;
endmodule

// File: rtl/pov_remap_chk.sv
`timescale 1ns/1ps
module pov_remap_chk #(
    parameter int NUM_PAGES = 128,
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [IDX_W-1:0]     rsp_page,
    input logic [ADDR_W-1:0]    rsp_addr,
    input logic                 glock,
    input logic                 blk_en,
    input logic [NUM_PAGES-1:0] pg_busy
);
    // R12: one-cycle lookup
    a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R4: hits only with a valid response, and keep the page offset
    a_r4_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
    a_r4_hit_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || rsp_addr == ADDR_W'({rsp_page, $past(req_addr[11:0])})));
    // R5: misses pass the address through
    a_r5_miss_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_hit || rsp_addr == $past(req_addr)));
    // R8: global lock is sticky
    a_r8_glock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        glock |=> glock);
    // R10: block mode blocks every page hit
    a_r10_block_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        blk_en |=> !rsp_hit);
    // R7: an activated page never drops its busy flag
    a_r7_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pg_busy) & ~pg_busy) == '0));
endmodule

bind pov_remap_ctrl pov_remap_chk #(.NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_page(rsp_page),
    .rsp_addr(rsp_addr), .glock(glock), .blk_en(blk_en), .pg_busy(pg_busy)
);

// File: tb/pov_remap_ctrl_test.sv
`timescale 1ns/1ps
module pov_remap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_global = 1'b0;
    logic [6:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [6:0]  rsp_page;
    logic [31:0] rsp_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] rd;
    logic        l_valid, l_hit;
    logic [6:0]  l_page;
    logic [31:0] l_addr;

    pov_remap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_global(cfg_global), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_page(rsp_page),
        .rsp_addr(rsp_addr)
    );

    always #2.5 clk = ~clk;

    // lookup vectors: {address, expected hit, expected page, expected rsp_addr}
    localparam logic [71:0] LK_VEC [6] = '{
        {32'h12345ABC, 1'b1, 7'd5,   32'h00005ABC},  // R6: pages 5 and 9 both match
        {32'h00040000, 1'b1, 7'd0,   32'h00000000},  // R4: lowest page
        {32'hFFFFF123, 1'b1, 7'd127, 32'h0007F123},  // R4: highest page
        {32'h00777010, 1'b0, 7'd0,   32'h00777010},  // R5: stored but not enabled
        {32'h00041000, 1'b0, 7'd0,   32'h00041000},  // R5: neighbour page
        {32'h12344FFF, 1'b0, 7'd0,   32'h12344FFF}   // R5: neighbour page
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic glb, input logic [6:0] idx, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_global = glb; cfg_idx = idx; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic glb, input logic [6:0] idx);
        cfg_rd = 1'b1; cfg_global = glb; cfg_idx = idx;
        @(posedge clk); @(negedge clk);
        cfg_rd = 1'b0;
        rd = cfg_rdata;
    endtask

    task automatic look(input logic [31:0] a);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        l_valid = rsp_valid; l_hit = rsp_hit; l_page = rsp_page; l_addr = rsp_addr;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        rdreg(1'b0, 7'd0);   chk("R1 page0", rd, 32'h0);
        rdreg(1'b0, 7'd127); chk("R1 page127", rd, 32'h0);
        rdreg(1'b1, 7'd0);   chk("R1 ctrl", rd, 32'h007F0010);
        rdreg(1'b1, 7'd1);   chk("R1 block", rd, 32'h0);
        look(32'h00000ABC);  chk("R1 no hit", {31'b0, l_hit}, 32'h0);

        // R3 activation sequence, R2 layout
        wr(1'b0, 7'd5, 32'h90012345);
        rdreg(1'b0, 7'd5);   chk("R3 init in progress", rd, 32'h94012345);
        rdreg(1'b0, 7'd5);   chk("R2 R3 active word", rd, 32'h91012345);

        wr(1'b0, 7'd9,   32'h10012345);
        wr(1'b0, 7'd0,   32'h10000040);
        wr(1'b0, 7'd127, 32'h100FFFFF);
        wr(1'b0, 7'd3,   32'h00000777);
        rdreg(1'b0, 7'd3);   chk("R2 disabled entry", rd, 32'h00000777);
        rdreg(1'b0, 7'd127); chk("R2 page127 word", rd, 32'h010FFFFF | 32'h10000000);

        // R4 R5 R6 lookup table
        for (int i = 0; i < 6; i++) begin
            look(LK_VEC[i][71:40]);
            chk("R12 valid", {31'b0, l_valid}, 32'h1);
            chk("R4 R5 R6 hit", {31'b0, l_hit}, {31'b0, LK_VEC[i][39]});
            chk("R4 R6 page", {25'b0, l_page}, {25'b0, LK_VEC[i][38:32]});
            chk("R4 R5 addr", l_addr, LK_VEC[i][31:0]);
        end
        @(posedge clk); @(negedge clk);
        chk("R12 idle after lookup", {31'b0, rsp_valid}, 32'h0);

        // R7 write-once and page lock
        wr(1'b0, 7'd5, 32'h10000AAA);
        rdreg(1'b0, 7'd5);  chk("R7 busy page unchanged", rd, 32'h91012345);
        wr(1'b0, 7'd3, 32'h08000888);
        rdreg(1'b0, 7'd3);  chk("R7 lock stored", rd, 32'h08000888);
        wr(1'b0, 7'd3, 32'h10000999);
        rdreg(1'b0, 7'd3);  chk("R7 locked page unchanged", rd, 32'h08000888);
        look(32'h00999000); chk("R7 locked page no hit", {31'b0, l_hit}, 32'h0);

        // R11 control fields
        wr(1'b1, 7'd0, 32'h00FF0009);
        rdreg(1'b1, 7'd0);  chk("R11 ctrl rw and ro", rd, 32'h007F0019);

        // R10 block mode
        wr(1'b1, 7'd1, 32'h10000000);
        rdreg(1'b1, 7'd1);  chk("R10 block enabled", rd, 32'h11000000);
        look(32'h12345ABC);
        chk("R10 no hit in block mode", {31'b0, l_hit}, 32'h0);
        chk("R10 passthrough addr", l_addr, 32'h12345ABC);
        wr(1'b1, 7'd1, 32'h30000000);
        rdreg(1'b1, 7'd1);  chk("R10 disable wins", rd, 32'h0);
        look(32'h12345ABC);
        chk("R10 hit restored", {25'b0, l_page, l_hit}, {25'b0, 7'd5, 1'b1});

        // R8 global lock
        wr(1'b1, 7'd0, 32'h00000004);
        rdreg(1'b1, 7'd0);  chk("R8 lock set", rd, 32'h007F0014);
        wr(1'b1, 7'd0, 32'h00000000);
        rdreg(1'b1, 7'd0);  chk("R8 lock sticky", rd, 32'h007F0014);
        wr(1'b0, 7'd20, 32'h10000123);
        rdreg(1'b0, 7'd20); chk("R8 page write ignored", rd, 32'h0);
        wr(1'b1, 7'd1, 32'h10000000);
        rdreg(1'b1, 7'd1);  chk("R8 block write ignored", rd, 32'h0);
        look(32'h00123000); chk("R8 no hit", {31'b0, l_hit}, 32'h0);

        // R1 again after a second reset
        do_reset();
        rdreg(1'b0, 7'd5);  chk("R1 page cleared", rd, 32'h0);
        rdreg(1'b1, 7'd0);  chk("R1 ctrl cleared", rd, 32'h007F0010);
        look(32'h12345ABC); chk("R1 no hit after reset", {31'b0, l_hit}, 32'h0);

        // R9 block lock
        wr(1'b1, 7'd1, 32'h08000000);
        rdreg(1'b1, 7'd1);  chk("R9 block lock set", rd, 32'h08000000);
        wr(1'b0, 7'd10, 32'h10000222);
        rdreg(1'b0, 7'd10); chk("R9 page write ignored", rd, 32'h0);
        look(32'h00222000); chk("R9 no hit", {31'b0, l_hit}, 32'h0);
        wr(1'b1, 7'd1, 32'h10000000);
        rdreg(1'b1, 7'd1);  chk("R9 block write ignored", rd, 32'h08000000);
        wr(1'b1, 7'd0, 32'h00000001);
        rdreg(1'b1, 7'd0);  chk("R9 ctrl still writable", rd, 32'h007F0011);

        finish_run();
    end
endmodule